// File: doc/BRIEF.md
# Integer Multiply Unit with HI/LO Result Registers and Read Interlock

This block is the multiply side of a small in-order processor. It keeps two result registers: one for the upper half of a product (HI) and one for the lower half (LO). One command arrives per cycle, qualified by a valid bit. A command can do one of four things:

- start a signed or unsigned 32x32 multiply;
- copy one operand straight into HI or LO;
- return HI or LO on a read port, to be written to a general register;
- do nothing (divides and unused codes).

A multiply takes one cycle. Its result can be read in the very next slot.

Reading HI or LO opens a two-slot danger window. Any multiply or register write that arrives inside that window is held with `stall` until the window closes. The pipeline treats a stalled cycle as a bubble, so every clock cycle is one issue slot, and the window closes two cycles after the read at most. If LO is overwritten after a multiply whose HI half has not been read yet, HI is marked as no longer trustworthy. A later read of HI reports this on a flag output.

Top module: `hilo_mul_unit`

## Requirements
- R1: Command code 1 (signed multiply) treats `opnd_a` and `opnd_b` as two's complement. It loads the upper 32 bits of the 64-bit product into HI and the lower 32 bits into LO. The most negative value times -1 gives HI=0x00000000, LO=0x80000000.
- R2: Command code 2 (unsigned multiply) does the same with both operands treated as unsigned, so 0x80000000 times 0xFFFFFFFF gives HI=0x7FFFFFFF, LO=0x80000000.
- R3: While valid is high with code 3 (read HI) or code 4 (read LO), `rd_data` shows the current register value in the same cycle. A multiply accepted in one cycle is visible to a read in the next cycle. In every other cycle `rd_data` is zero.
- R4: Code 5 loads HI from `opnd_a` and code 6 loads LO from `opnd_a`. The other register keeps its value.
- R5: A multiply or write command (codes 1, 2, 5, 6) that arrives k cycles after an accepted read, with k = 1 or 2, raises `stall` for 3-k cycles and is accepted in the cycle after that. A stalled command changes nothing.
- R6: Reads, idle cycles, divides and unused codes never stall. A read that falls inside an open window restarts the window at two slots.
- R7: Code 6 accepted after a multiply, before HI has been read, marks HI as invalid. `rd_hi_bad` is high during a read of HI while the mark is set, and low at all other times. A multiply or a code 5 write clears the mark.
- R8: Codes 7 and 8 (divides), code 0 and codes 9 to 15 change neither HI, LO nor the invalid mark.
- R9: Synchronous active-high reset clears HI, LO, the window and the invalid mark, so reads right after reset return zero and do not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command code (see requirements) |
| opnd_a | input | 32 | First operand; data source for register writes |
| opnd_b | input | 32 | Second operand |
| rd_data | output | 32 | HI or LO value during a read, zero otherwise |
| rd_hi_bad | output | 1 | HI read returns a value marked invalid |
| stall | output | 1 | Current command is held and must be presented again |

## Verification
The bench goes after the sign corners of the multiplier. A design that sign-extends the operands for unsigned multiplies, or zero-extends them for signed ones, gets the HI word wrong for 0x80000000 times -1 and for random operands with high bits set. It measures the stall length for a multiply placed zero, one and two slots after a read, and after two back-to-back reads. A window counted from the wrong slot, or not restarted by a second read, shows up as a stall that is one cycle too long or too short. It also checks that a register write leaves the other register alone, that divides leave the state untouched, and that the invalid mark on HI is set and cleared only by the sequences that R7 names.

// File: rtl/hilo_mul_unit.sv
module hilo_mul_unit #(
  parameter int DW  = 32,
  parameter int GAP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] rd_data,
  output logic          rd_hi_bad,
  output logic          stall
);
  localparam int          CW      = $clog2(GAP + 1);
  localparam int          PW      = 2 * DW;
  localparam logic [3:0]  OP_MULS = 4'd1;
  localparam logic [3:0]  OP_MULU = 4'd2;
  localparam logic [3:0]  OP_RDHI = 4'd3;
  localparam logic [3:0]  OP_RDLO = 4'd4;
  localparam logic [3:0]  OP_WRHI = 4'd5;
  localparam logic [3:0]  OP_WRLO = 4'd6;

  logic [DW-1:0] hi_q, lo_q;
  logic [CW-1:0] gap_q;
  logic          unread_q, hi_bad_q;
  logic [PW-1:0] ext_a, ext_b, prod;

  wire is_mul = (cmd_op == OP_MULS) || (cmd_op == OP_MULU);
  wire is_wr  = (cmd_op == OP_WRHI) || (cmd_op == OP_WRLO);
  wire is_rd  = (cmd_op == OP_RDHI) || (cmd_op == OP_RDLO);
  wire sgn    = (cmd_op == OP_MULS);

  assign stall = cmd_valid && (is_mul || is_wr) && (gap_q != '0);
  wire   go    = cmd_valid && !stall;

  assign ext_a = {{DW{sgn & opnd_a[DW-1]}}, opnd_a};
  assign ext_b = {{DW{sgn & opnd_b[DW-1]}}, opnd_b};
  assign prod  = ext_a * ext_b;

  assign rd_data   = !(cmd_valid && is_rd) ? '0 :
                     (cmd_op == OP_RDHI) ? hi_q : lo_q;
  assign rd_hi_bad = cmd_valid && (cmd_op == OP_RDHI) && hi_bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      gap_q    <= '0;
      unread_q <= 1'b0;
      hi_bad_q <= 1'b0;
    end else begin
      if (go && is_rd)
        gap_q <= CW'(GAP);
      else if (gap_q != '0)
        gap_q <= gap_q - CW'(1);
      if (go) begin
        case (cmd_op)
          OP_MULS, OP_MULU: begin
            hi_q     <= prod[PW-1:DW];
            lo_q     <= prod[DW-1:0];
            unread_q <= 1'b1;
            hi_bad_q <= 1'b0;
          end
          OP_RDHI: unread_q <= 1'b0;
          OP_WRHI: begin
            hi_q     <= opnd_a;
            unread_q <= 1'b0;
            hi_bad_q <= 1'b0;
          end
          OP_WRLO: begin
            lo_q <= opnd_a;
            if (unread_q) hi_bad_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hilo_mul_chk.sv
module hilo_mul_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [DW-1:0] rd_data,
  input logic          rd_hi_bad,
  input logic          stall,
  input logic [DW-1:0] hi_q,
  input logic [DW-1:0] lo_q
);
  wire acc    = cmd_valid && !stall;
  wire rd_op  = (cmd_op == 4'd3) || (cmd_op == 4'd4);
  wire mod_op = (cmd_op == 4'd1) || (cmd_op == 4'd2) || (cmd_op == 4'd5) || (cmd_op == 4'd6);

  // R5
  stall_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && rd_op) |=> (!(cmd_valid && mod_op) || stall));

  // R6
  only_mod_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (cmd_valid && mod_op));

  // R1 R2
  prod_low_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op == 4'd1 || cmd_op == 4'd2)) |=> (lo_q == DW'($past(opnd_a) * $past(opnd_b))));

  // R4
  wrhi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 4'd5) |=> $stable(lo_q));

  // R4
  wrlo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 4'd6) |=> $stable(hi_q));

  // R8
  div_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op == 4'd7 || cmd_op == 4'd8)) |=> ($stable(hi_q) && $stable(lo_q)));

  // R7
  bad_only_on_hi_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hi_bad |-> (cmd_valid && cmd_op == 4'd3));

  // R3
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && rd_op) |-> (rd_data == '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (hi_q == '0 && lo_q == '0));
endmodule

bind hilo_mul_unit hilo_mul_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .rd_data(rd_data),
  .rd_hi_bad(rd_hi_bad), .stall(stall), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_hilo_mul_unit.sv
module test_hilo_mul_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] rd_data;
  logic        rd_hi_bad;
  logic        stall;

  always #10 clk = ~clk;

  hilo_mul_unit i_hilo_mul_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .rd_data(rd_data),
    .rd_hi_bad(rd_hi_bad), .stall(stall)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] q_data[$];
  bit          q_bad[$];
  string       q_tag[$];
  logic [31:0] m_hi = '0, m_lo = '0;
  bit          m_bad = 1'b0, m_pend = 1'b0;
  int          m_win = 0;

  function automatic void check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    int w, want, n;
    bit mod, rd;
    longint sp;
    longint unsigned up;
    mod = (op == 4'd1) || (op == 4'd2) || (op == 4'd5) || (op == 4'd6);
    rd  = (op == 4'd3) || (op == 4'd4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; opnd_a = a; opnd_b = b;
    w = m_win;
    want = mod ? w : 0;
    if (rd) begin
      q_data.push_back(op == 4'd3 ? m_hi : m_lo);
      q_bad.push_back(op == 4'd3 && m_bad);
      q_tag.push_back(req);
    end
    n = 0;
    #1;
    while (stall && n < 8) begin
      n++;
      @(negedge clk);
      #1;
    end
    check(n == want, mod ? "R5" : "R6", "stall cycles", 64'(n), 64'(want));
    case (op)
      4'd1: begin
        sp = longint'($signed(a)) * longint'($signed(b));
        m_hi = sp[63:32]; m_lo = sp[31:0]; m_pend = 1'b1; m_bad = 1'b0;
      end
      4'd2: begin
        up = longint'({32'b0, a}) * longint'({32'b0, b});
        m_hi = up[63:32]; m_lo = up[31:0]; m_pend = 1'b1; m_bad = 1'b0;
      end
      4'd3: m_pend = 1'b0;
      4'd5: begin m_hi = a; m_pend = 1'b0; m_bad = 1'b0; end
      4'd6: begin m_lo = a; if (m_pend) m_bad = 1'b1; end
      default: ;
    endcase
    m_win = rd ? 2 : (mod ? 0 : (w > 0 ? w - 1 : 0));
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd3; opnd_a = $urandom; opnd_b = $urandom;
    #1;
    check(rd_data == 32'h0, "R3", "rd_data when idle", 64'(rd_data), 64'h0);
    check(!stall, "R6", "stall when idle", 64'(stall), 64'h0);
    m_win = m_win > 0 ? m_win - 1 : 0;
  endtask

  task automatic mul_and_read(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    issue(op, a, b, req);
    issue(4'd3, '0, '0, req);
    issue(4'd4, '0, '0, req);
  endtask

  // monitor: pops the scoreboard when a read is accepted
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (!rst && cmd_valid && !stall && (cmd_op == 4'd3 || cmd_op == 4'd4)) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R3", "unexpected read", 64'(rd_data), 64'h0);
        end else begin
          logic [31:0] ed;
          bit eb;
          string et;
          ed = q_data.pop_front();
          eb = q_bad.pop_front();
          et = q_tag.pop_front();
          check(rd_data == ed, et, "rd_data", 64'(rd_data), 64'(ed));
          check(rd_hi_bad == eb, "R7", "rd_hi_bad", 64'(rd_hi_bad), 64'(eb));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    issue(4'd3, '0, '0, "R9");
    issue(4'd4, '0, '0, "R9");
    idle(); idle();

    // R1 / R2 corners
    mul_and_read(4'd1, 32'h8000_0000, 32'hFFFF_FFFF, "R1");
    mul_and_read(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R2");
    mul_and_read(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    mul_and_read(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    mul_and_read(4'd1, 32'h7FFF_FFFF, 32'h8000_0000, "R1");
    mul_and_read(4'd2, 32'h0000_0000, 32'hDEAD_BEEF, "R2");
    for (int i = 0; i < 12; i++) begin
      mul_and_read(4'd1, $urandom, $urandom, "R1");
      mul_and_read(4'd2, $urandom, $urandom, "R2");
    end

    // R5 window lengths: zero, one and two slots after a read
    issue(4'd4, '0, '0, "R3");
    issue(4'd1, 32'd3, 32'd5, "R5");
    issue(4'd4, '0, '0, "R3");
    idle();
    issue(4'd2, 32'd7, 32'd9, "R5");
    issue(4'd4, '0, '0, "R3");
    idle(); idle();
    issue(4'd5, 32'h1111_2222, '0, "R5");
    // R6 second read restarts window
    issue(4'd3, '0, '0, "R6");
    idle();
    issue(4'd3, '0, '0, "R6");
    issue(4'd6, 32'h3333_4444, '0, "R5");

    // R4 single-register writes
    issue(4'd5, 32'hCAFE_0001, '0, "R4");
    issue(4'd3, '0, '0, "R4");
    issue(4'd4, '0, '0, "R4");
    issue(4'd6, 32'hBEEF_0002, '0, "R4");
    issue(4'd3, '0, '0, "R4");
    issue(4'd4, '0, '0, "R4");

    // R7 invalid HI mark
    issue(4'd1, 32'd11, 32'hFFFF_FFF0, "R7");
    issue(4'd6, 32'h0000_0042, '0, "R7");
    issue(4'd3, '0, '0, "R7");
    issue(4'd4, '0, '0, "R7");
    issue(4'd2, 32'd2, 32'd3, "R7");
    issue(4'd3, '0, '0, "R7");
    issue(4'd6, 32'h0000_0099, '0, "R7");
    issue(4'd3, '0, '0, "R7");
    issue(4'd1, 32'd5, 32'd6, "R7");
    issue(4'd6, 32'h0000_0077, '0, "R7");
    issue(4'd5, 32'h0000_0055, '0, "R7");
    issue(4'd3, '0, '0, "R7");

    // R8 divides and unused codes do nothing
    issue(4'd1, 32'h1234_5678, 32'h9ABC_DEF0, "R8");
    issue(4'd4, '0, '0, "R8");
    issue(4'd7, 32'd100, 32'd7, "R8");
    issue(4'd8, 32'd100, 32'd7, "R8");
    issue(4'd0, 32'd1, 32'd1, "R8");
    issue(4'd9, 32'd1, 32'd1, "R8");
    issue(4'd15, 32'd1, 32'd1, "R8");
    issue(4'd3, '0, '0, "R8");
    issue(4'd4, '0, '0, "R8");

    idle(); idle(); idle();
    check(q_data.size() == 0, "R3", "reads left unserved", 64'(q_data.size()), 64'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule